// File: doc/BRIEF.md
# Backdoor Key Verification Controller

This block carries out the key-verification command of a flash controller's security unit. Software starts the command by clearing the command-complete flag. The block then checks that the command may run at all. It rejects the command when any of these holds: the two-bit key-enable setting is wrong, the command-index pointer is wrong, a data-loading command sequence is still open, or an earlier key attempt has failed since reset. A rejected command raises the access-error flag and returns at once.

When every precondition holds, the block takes a snapshot of the four key words held in the command registers. It compares them one word per clock against the four stored comparison words from the configuration area. The compare always takes the same number of cycles, whatever the data. If every word matches, the secured state is released until the next reset. A single mismatch raises the access-error flag. It also sets a lockout that rejects every later attempt until reset.

Top module: `bkey_verify`

## Requirements
- R1: After reset, cmd_done_o is 1, acc_err_o is 0 and unsecured_o is 0, and any earlier lockout is gone.
- R2: A launch is accepted only when launch_i is 1 on a clock edge while cmd_done_o is 1 and acc_err_o is 0. A launch while acc_err_o is 1, or while a compare is running, changes no output.
- R3: An accepted launch with key_en_i different from 2'b10 sets acc_err_o at that edge. cmd_done_o stays 1 and unsecured_o does not change.
- R4: An accepted launch with cmd_idx_i different from 3'b100 sets acc_err_o at that edge, with cmd_done_o staying 1.
- R5: An accepted launch while seq_active_i is 1 sets acc_err_o at that edge, with cmd_done_o staying 1.
- R6: When the preconditions hold, key word i (key_words_i bits [16i+15:16i]) is compared with stored word i (ref_words_i bits [16i+15:16i]). Word 0 is the stored word at the lowest configuration offset. If all four words are equal, unsecured_o becomes 1 and acc_err_o stays 0.
- R7: A compare lowers cmd_done_o for exactly 4 cycles after the accepting edge, whether the key matches or not. With any word different, acc_err_o becomes 1 when cmd_done_o returns to 1.
- R8: After a mismatch, every later accepted launch sets acc_err_o at once, without a compare and without releasing security, even with a correct key, until reset.
- R9: A 1 on err_clr_i clears acc_err_o at the next clock edge.
- R10: Once unsecured_o is 1, it stays 1 until reset, even if a later attempt fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Software write that clears the command-complete flag (starts the command) |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the access-error flag |
| key_en_i | input | 2 | Key-enable field of the security configuration; 2'b10 enables the command |
| cmd_idx_i | input | 3 | Command register index pointer; must be 3'b100 at launch |
| seq_active_i | input | 1 | A data-loading command sequence is still active |
| key_words_i | input | 64 | Four key words from the command registers, word 0 in the low bits |
| ref_words_i | input | 64 | Four stored comparison words, word 0 in the low bits |
| cmd_done_o | output | 1 | Command-complete flag |
| acc_err_o | output | 1 | Access-error flag |
| unsecured_o | output | 1 | Security released |

## Verification
The bench builds the block with its default parameters: four 16-bit words, with a snapshot of the stored words taken at launch. It uses these values because they keep the compare window at four cycles. That window can be counted cycle by cycle, and single-word differences can be placed in each word position, including the last. Random episodes start from reset and mix valid launches with bad enable codes, bad index values, open sequences and ignored launches. They reach the lockout and the sticky release in many orders.

// File: rtl/bkv_pkg.sv
package bkv_pkg;

   // reasons a launch is refused before any compare starts
   typedef struct packed {
      logic bad_enable;
      logic bad_index;
      logic seq_open;
      logic locked_out;
   } bkv_gate_t;

   typedef enum logic [1:0] {
      BKV_NONE   = 2'd0,
      BKV_REJECT = 2'd1,
      BKV_PASS   = 2'd2,
      BKV_FAIL   = 2'd3
   } bkv_result_e;

   function automatic logic bkv_any_block(input bkv_gate_t g);
      return g.bad_enable | g.bad_index | g.seq_open | g.locked_out;
   endfunction

endpackage

// File: rtl/bkv_precheck.sv
module bkv_precheck
   import bkv_pkg::*;
#(
   parameter int          EN_W     = 2,
   parameter int          IDX_W    = 3,
   parameter logic [EN_W-1:0]  EN_CODE  = 2'b10,
   parameter logic [IDX_W-1:0] IDX_CODE = 3'b100
) (
   input  logic [EN_W-1:0]  key_en_i,
   input  logic [IDX_W-1:0] cmd_idx_i,
   input  logic             seq_active_i,
   input  logic             locked_i,
   output bkv_gate_t        gate_o,
   output logic             reject_o
);

   initial begin
      assert (EN_W >= 1) else $error("bkv_precheck: EN_W must be at least 1");
      assert (IDX_W >= 1) else $error("bkv_precheck: IDX_W must be at least 1");
   end

   always_comb begin
      gate_o.bad_enable = (key_en_i != EN_CODE);
      gate_o.bad_index  = (cmd_idx_i != IDX_CODE);
      gate_o.seq_open   = seq_active_i;
      gate_o.locked_out = locked_i;
   end

   assign reject_o = bkv_any_block(gate_o);

endmodule

// File: rtl/bkv_word_cmp.sv
module bkv_word_cmp #(
   parameter int WORD_W    = 16,
   parameter int KEY_WORDS = 4,
   parameter bit SNAP_REF  = 1'b1,
   localparam int FLAT_W   = WORD_W * KEY_WORDS,
   localparam int CNT_W    = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [FLAT_W-1:0] key_i,
   input  logic [FLAT_W-1:0] ref_i,
   output logic              busy_o,
   output logic              fin_o,
   output logic              pass_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_WORDS - 1);

   initial begin
      assert (WORD_W >= 1) else $error("bkv_word_cmp: WORD_W must be at least 1");
      assert (KEY_WORDS >= 1) else $error("bkv_word_cmp: KEY_WORDS must be at least 1");
   end

   logic [KEY_WORDS-1:0][WORD_W-1:0] key_q;
   logic [KEY_WORDS-1:0][WORD_W-1:0] ref_w;
   logic [KEY_WORDS-1:0]             word_neq;
   logic [CNT_W-1:0]                 cnt_q;
   logic                             busy_q;
   logic                             miss_q;
   logic                             miss_now;

   // key words are always captured at launch
   for (genvar w = 0; w < KEY_WORDS; w++) begin : g_key
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       key_q[w] <= '0;
         else if (start_i) key_q[w] <= key_i[w*WORD_W +: WORD_W];
      end
   end

   // stored words: snapshot at launch, or read live from the port
   if (SNAP_REF) begin : g_ref_snap
      logic [KEY_WORDS-1:0][WORD_W-1:0] ref_q;
      for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ref_q[w] <= '0;
            else if (start_i) ref_q[w] <= ref_i[w*WORD_W +: WORD_W];
         end
         assign ref_w[w] = ref_q[w];
      end
   end else begin : g_ref_live
      for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
         assign ref_w[w] = ref_i[w*WORD_W +: WORD_W];
      end
   end

   for (genvar w = 0; w < KEY_WORDS; w++) begin : g_neq
      assign word_neq[w] = |(key_q[w] ^ ref_w[w]);
   end

   // one word per cycle; every word is visited, so timing does not depend on data
   assign miss_now = miss_q | word_neq[cnt_q];
   assign fin_o    = busy_q && (cnt_q == LAST);
   assign pass_o   = fin_o && !miss_now;
   assign busy_o   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         miss_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         miss_q <= 1'b0;
      end else if (busy_q) begin
         miss_q <= miss_now;
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   AST_CMP_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST && !start_i) |=> busy_q); // R7
   AST_CMP_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST && !start_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R7
   AST_CMP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_o && !start_i) |=> !busy_q); // R7

endmodule

// File: rtl/bkv_status.sv
module bkv_status (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   input  logic err_clr_i,
   input  logic reject_i,
   input  logic cmp_fin_i,
   input  logic cmp_pass_i,
   output logic accept_o,
   output logic start_cmp_o,
   output logic done_o,
   output logic err_o,
   output logic unsec_o,
   output logic lock_o
);

   logic done_q, err_q, unsec_q, lock_q;
   logic set_err, fail_now, pass_now;

   assign accept_o    = launch_i && done_q && !err_q;
   assign start_cmp_o = accept_o && !reject_i;
   assign fail_now    = cmp_fin_i && !cmp_pass_i;
   assign pass_now    = cmp_fin_i && cmp_pass_i;
   assign set_err     = (accept_o && reject_i) || fail_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b1;
         err_q   <= 1'b0;
         unsec_q <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         if (start_cmp_o)    done_q <= 1'b0;
         else if (cmp_fin_i) done_q <= 1'b1;

         if (set_err)        err_q <= 1'b1;
         else if (err_clr_i) err_q <= 1'b0;

         if (pass_now) unsec_q <= 1'b1;
         if (fail_now) lock_q  <= 1'b1;
      end
   end

   assign done_o  = done_q;
   assign err_o   = err_q;
   assign unsec_o = unsec_q;
   assign lock_o  = lock_q;

   AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_cmp_o |=> !done_q); // R2
   AST_IGNORED_WHEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_i && err_q && !err_clr_i) |=> (err_q && done_q == $past(done_q))); // R2
   AST_PASS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      pass_now |=> (unsec_q && done_q && !err_q)); // R6
   AST_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      fail_now |=> (err_q && lock_q && done_q)); // R7
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q); // R8
   AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && err_clr_i) |=> !err_q); // R9
   AST_UNSEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      unsec_q |=> unsec_q); // R10

endmodule

// File: rtl/bkey_verify.sv
module bkey_verify
   import bkv_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int KEY_WORDS = 4,
   parameter int EN_W      = 2,
   parameter int IDX_W     = 3,
   parameter logic [EN_W-1:0]  EN_CODE  = 2'b10,
   parameter logic [IDX_W-1:0] IDX_CODE = 3'b100,
   parameter bit SNAP_REF  = 1'b1,
   localparam int FLAT_W   = WORD_W * KEY_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              err_clr_i,
   input  logic [EN_W-1:0]   key_en_i,
   input  logic [IDX_W-1:0]  cmd_idx_i,
   input  logic              seq_active_i,
   input  logic [FLAT_W-1:0] key_words_i,
   input  logic [FLAT_W-1:0] ref_words_i,
   output logic              cmd_done_o,
   output logic              acc_err_o,
   output logic              unsecured_o
);

   initial begin
      assert (KEY_WORDS <= 64) else $error("bkey_verify: KEY_WORDS too large");
   end

   bkv_gate_t gate;
   logic      reject, accept, start_cmp, locked;
   logic      cmp_busy, cmp_fin, cmp_pass;

   bkv_precheck #(
      .EN_W(EN_W), .IDX_W(IDX_W), .EN_CODE(EN_CODE), .IDX_CODE(IDX_CODE)
   ) u_pre (
      .key_en_i    (key_en_i),
      .cmd_idx_i   (cmd_idx_i),
      .seq_active_i(seq_active_i),
      .locked_i    (locked),
      .gate_o      (gate),
      .reject_o    (reject)
   );

   bkv_word_cmp #(
      .WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS), .SNAP_REF(SNAP_REF)
   ) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_cmp),
      .key_i  (key_words_i),
      .ref_i  (ref_words_i),
      .busy_o (cmp_busy),
      .fin_o  (cmp_fin),
      .pass_o (cmp_pass)
   );

   bkv_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch_i),
      .err_clr_i  (err_clr_i),
      .reject_i   (reject),
      .cmp_fin_i  (cmp_fin),
      .cmp_pass_i (cmp_pass),
      .accept_o   (accept),
      .start_cmp_o(start_cmp),
      .done_o     (cmd_done_o),
      .err_o      (acc_err_o),
      .unsec_o    (unsecured_o),
      .lock_o     (locked)
   );

   AST_BAD_ENABLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && key_en_i != EN_CODE) |=> (acc_err_o && cmd_done_o)); // R3
   AST_BAD_INDEX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cmd_idx_i != IDX_CODE) |=> (acc_err_o && cmd_done_o)); // R4
   AST_SEQ_OPEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && seq_active_i) |=> (acc_err_o && cmd_done_o)); // R5
   AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && locked) |=> (acc_err_o && cmd_done_o && unsecured_o == $past(unsecured_o))); // R8
   AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_busy |-> !cmd_done_o); // R7

endmodule

// File: tb/bkey_verify_test.sv
`timescale 1ns/1ps
module bkey_verify_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_i = 1'b0;
   logic        err_clr_i = 1'b0;
   logic [1:0]  key_en_i = 2'b10;
   logic [2:0]  cmd_idx_i = 3'b100;
   logic        seq_active_i = 1'b0;
   logic [63:0] key_words_i = '0;
   logic [63:0] ref_words_i = '0;
   logic        cmd_done_o, acc_err_o, unsecured_o;

   int total = 0;
   int bad   = 0;
   bit m_err, m_lock, m_unsec;

   always #2.5 clk = ~clk;

   bkey_verify uut (
      .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .err_clr_i(err_clr_i),
      .key_en_i(key_en_i), .cmd_idx_i(cmd_idx_i), .seq_active_i(seq_active_i),
      .key_words_i(key_words_i), .ref_words_i(ref_words_i),
      .cmd_done_o(cmd_done_o), .acc_err_o(acc_err_o), .unsecured_o(unsecured_o)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // 0 ignored, 1 rejected at once, 2 pass, 3 mismatch
   function automatic int expect_kind(input logic [63:0] k, input logic [63:0] r,
                                      input logic [1:0] en, input logic [2:0] idx, input logic seq);
      if (m_err) return 0;
      if (en != 2'b10 || idx != 3'b100 || seq || m_lock) return 1;
      return (k == r) ? 2 : 3;
   endfunction

   task automatic do_reset();
      launch_i = 0; err_clr_i = 0; rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      m_err = 0; m_lock = 0; m_unsec = 0;
      chk(cmd_done_o === 1'b1, "R1", "done after reset", cmd_done_o, 1);
      chk(acc_err_o === 1'b0, "R1", "err after reset", acc_err_o, 0);
      chk(unsecured_o === 1'b0, "R1", "unsecured after reset", unsecured_o, 0);
   endtask

   task automatic clear_err();
      err_clr_i = 1;
      @(negedge clk);
      err_clr_i = 0;
      m_err = 0;
      chk(acc_err_o === 1'b0, "R9", "err after clear", acc_err_o, 0);
   endtask

   task automatic attempt(input logic [63:0] k, input logic [63:0] r, input logic [1:0] en,
                          input logic [2:0] idx, input logic seq, input bit extra, input string req);
      int kind, low, e_low;
      kind = expect_kind(k, r, en, idx, seq);
      key_words_i = k; ref_words_i = r; key_en_i = en; cmd_idx_i = idx; seq_active_i = seq;
      launch_i = 1;
      @(negedge clk);
      launch_i = 0;
      low = 0;
      while (cmd_done_o !== 1'b1 && low < 20) begin
         launch_i = (extra && low == 0);
         low++;
         @(negedge clk);
      end
      launch_i = 0;
      case (kind)
         0: ;
         1: m_err = 1;
         2: m_unsec = 1;
         default: begin m_err = 1; m_lock = 1; end
      endcase
      e_low = (kind >= 2) ? 4 : 0;
      chk(low == e_low, (kind >= 2) ? "R7" : "R2", {req, " done-low cycles"}, low, e_low);
      chk(acc_err_o === m_err, req, "access error", acc_err_o, m_err);
      chk(unsecured_o === m_unsec, (kind == 3) ? "R10" : req, "unsecured", unsecured_o, m_unsec);
   endtask

   function automatic logic [63:0] flip_word(input logic [63:0] v, input int w, input int b);
      logic [63:0] t = v;
      t[w*16 + b] = ~t[w*16 + b];
      return t;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] kk;
      void'($urandom(32'h5eed_0042));
      kk = 64'h1234_5678_9abc_def0;

      // R1 R6: correct key releases security
      do_reset();
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b0, "R6");
      // R10: second pass keeps release, later mismatch keeps it too
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b0, "R10");
      attempt(flip_word(kk, 0, 0), kk, 2'b10, 3'b100, 1'b0, 1'b0, "R10");

      // R7: mismatch in the last word, then R2 ignored launch, R9 clear, R8 lockout
      do_reset();
      attempt(flip_word(kk, 3, 15), kk, 2'b10, 3'b100, 1'b0, 1'b0, "R7");
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b0, "R2");
      clear_err();
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b0, "R8");
      clear_err();
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b0, "R8");
      // R1: reset removes the lockout
      do_reset();
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b1, "R2");

      // R3 R4 R5 rejection reasons
      do_reset();
      for (int e = 0; e < 4; e++) begin
         if (e == 2) continue;
         attempt(kk, kk, 2'(e), 3'b100, 1'b0, 1'b0, "R3");
         clear_err();
      end
      for (int i = 0; i < 8; i++) begin
         if (i == 4) continue;
         attempt(kk, kk, 2'b10, 3'(i), 1'b0, 1'b0, "R4");
         clear_err();
      end
      attempt(kk, kk, 2'b10, 3'b100, 1'b1, 1'b0, "R5");
      clear_err();
      attempt(kk, kk, 2'b10, 3'b100, 1'b0, 1'b0, "R6");

      // random episodes
      for (int ep = 0; ep < 40; ep++) begin
         do_reset();
         for (int a = 0; a < 6; a++) begin
            logic [63:0] r, k;
            logic [1:0]  en;
            logic [2:0]  idx;
            logic        seq;
            r   = {$urandom, $urandom};
            k   = ($urandom % 2) ? r : flip_word(r, $urandom % 4, $urandom % 16);
            en  = ($urandom % 4 != 0) ? 2'b10 : 2'($urandom);
            idx = ($urandom % 4 != 0) ? 3'b100 : 3'($urandom);
            seq = ($urandom % 7 == 0);
            if (m_err && ($urandom % 10 < 7)) clear_err();
            attempt(k, r, en, idx, seq, ($urandom % 5 == 0), "R6");
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule